// File: doc/BRIEF.md
# Byte-Wide SPI Master with Register Port

This block is a master-only SPI controller. A host reaches it through a small synchronous byte-register port with five registers: control, status, data, extension and select. Each byte written to the data register joins a transmit queue. The shift engine takes bytes from that queue one at a time and performs a full-duplex 8-bit exchange, most significant bit first. Each byte received during an exchange is pushed into a receive queue, which the host drains by reading the data register.

The serial clock is derived from the system clock. A 4-bit prescaler code selects the divide ratio. Clock polarity and clock phase are programmable, giving all four SPI modes. A select register drives active-low chip-select pins, one pin per bit.

A completion flag, and an optional interrupt, report progress in units of a programmable number of exchanges. Clearing the core-enable bit stops the engine and empties both queues. Host access is a single-cycle strobe with no back-pressure: a write takes effect at the clock edge where `reg_sel && reg_wr` is high. Read data is combinational from `reg_addr`. A read of the data register removes the oldest received byte at that same edge.

Top module: `spim_core`

## Requirements
- R1: After reset the control, extension and select registers read 0x00. Status reads 0x05 (both queues empty). A data read returns 0x00. `ss_n` is all ones, `irq` is 0 and `sck` is 0. Register offsets:
  - 0 = control: bit7 interrupt enable, bit6 core enable, bit4 master, bit3 polarity, bit2 phase, bits1:0 prescaler low.
  - 1 = status: bit7 done flag, bit6 collision, bit3 tx full, bit2 tx empty, bit1 rx full, bit0 rx empty.
  - 2 = data.
  - 3 = extension: bits7:6 count minus one, bits1:0 prescaler high.
  - 4 = select.
- R2: The prescaler code is {ext[1:0], ctl[1:0]}. It selects the SCK period, which is 2^(k+1) system clocks. The code-to-k mapping is: 0→0, 1→1, 4→2, 2→3, 3→4, codes 5 to 11→k equal to the code, and codes above 11→11.
- R3: Each exchange shifts 8 bits MSB first on `mosi` while capturing 8 bits from `miso`. With phase 0, capture happens on the leading SCK edge. With phase 1, capture happens on the trailing edge. The captured byte becomes readable from the data register.
- R4: While the core is enabled and no exchange is active, `sck` rests at the polarity bit level.
- R5: The transmit queue holds up to 4 bytes, which are exchanged back to back in write order. The receive queue returns bytes oldest first. Status bits report full and empty for each queue. A data read while the receive queue is empty returns 0x00 and removes nothing.
- R6: A data write while the transmit queue is full is discarded and sets the collision flag. Writing 1 to status bit 6 clears that flag.
- R7: While core enable is 0, both queues are emptied, any exchange is abandoned, and the exchange counter is cleared. Status then reads 0x05 plus any set flag bits.
- R8: The done flag sets when the count of completed exchanges reaches ext[7:6]+1, after which the count restarts. Writing 1 to status bit 7 clears the flag.
- R9: `irq` is high exactly when the done flag and the interrupt enable bit are both set.
- R10: `ss_n[n]` is low exactly when select-register bit n is 1. The pins change only on a write to the select register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 1 | Register access strobe |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data (combinational) |
| irq | output | 1 | Interrupt request |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_n | output | NSS | Active-low selects |

## Verification
A register write becomes visible on a read in the cycle after its edge. The one exception is `sck`, which follows a new polarity one cycle later still.

An exchange starts one cycle after its byte is queued. It completes 16·2^k cycles after that start, and the received byte and the flag appear in the following cycle.

The bench computes each burst's finishing time from these counts and adds margin before it reads status or data. It measures the SCK period between two rising edges against 2^(k+1). All sampling happens between edges, after the inputs have been driven.

// File: rtl/spim_pkg.sv
package spim_pkg;
  localparam int unsigned MAX_HALF_LOG = 11;

  localparam logic [2:0] OFS_CTL  = 3'd0;
  localparam logic [2:0] OFS_STAT = 3'd1;
  localparam logic [2:0] OFS_DATA = 3'd2;
  localparam logic [2:0] OFS_EXT  = 3'd3;
  localparam logic [2:0] OFS_SEL  = 3'd4;

  // prescaler code -> log2 of half SCK period in system clocks
  function automatic logic [3:0] half_log(input logic [3:0] code);
    case (code)
      4'd2:    half_log = 4'd3;
      4'd3:    half_log = 4'd4;
      4'd4:    half_log = 4'd2;
      4'd12, 4'd13, 4'd14, 4'd15: half_log = 4'd11;
      default: half_log = code;
    endcase
  endfunction
endpackage

// File: rtl/spim_fifo.sv
module spim_fifo #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flush,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         full,
  output logic         empty
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0] mem [DEPTH];
  logic [AW:0]  wptr, rptr;

  assign empty = (wptr == rptr);
  assign full  = (wptr[AW] != rptr[AW]) && (wptr[AW-1:0] == rptr[AW-1:0]);
  assign dout  = mem[rptr[AW-1:0]];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
    end else if (flush) begin
      wptr <= '0;
      rptr <= '0;
    end else begin
      if (push && !full) wptr <= wptr + 1'b1;
      if (pop && !empty) rptr <= rptr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (push && !full && !flush) mem[wptr[AW-1:0]] <= din;
  end
endmodule

// File: rtl/spim_shift.sv
module spim_shift
  import spim_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       cpol,
  input  logic       cpha,
  input  logic [3:0] hlog,
  input  logic       tx_avail,
  input  logic [7:0] tx_byte,
  input  logic       miso,
  output logic       pop,
  output logic       done,
  output logic [7:0] rx_byte,
  output logic       busy,
  output logic       sck,
  output logic       mosi
);
  localparam int unsigned CW = MAX_HALF_LOG + 1;

  logic [CW-1:0] cnt;
  logic [CW-1:0] half_m1;
  logic [3:0]    edge_n;
  logic [7:0]    tx_sr, rx_sr;
  logic          tick, leading;

  assign half_m1 = (CW'(1) << hlog) - CW'(1);
  assign tick    = (cnt == half_m1);
  assign leading = ~edge_n[0];
  assign pop     = en && !busy && tx_avail;
  assign done    = en && busy && tick && (edge_n == 4'd15);
  assign rx_byte = cpha ? {rx_sr[6:0], miso} : rx_sr;
  assign mosi    = tx_sr[7];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      cnt    <= '0;
      edge_n <= '0;
      sck    <= 1'b0;
      tx_sr  <= '0;
      rx_sr  <= '0;
    end else if (!en) begin
      busy <= 1'b0;
      cnt  <= '0;
      sck  <= cpol;
    end else if (!busy) begin
      sck <= cpol;
      if (tx_avail) begin
        busy   <= 1'b1;
        tx_sr  <= tx_byte;
        cnt    <= '0;
        edge_n <= '0;
      end
    end else if (tick) begin
      cnt    <= '0;
      sck    <= ~sck;
      edge_n <= edge_n + 4'd1;
      if (!cpha) begin
        if (leading) rx_sr <= {rx_sr[6:0], miso};
        else         tx_sr <= {tx_sr[6:0], 1'b0};
      end else begin
        if (leading) begin
          if (edge_n != 4'd0) tx_sr <= {tx_sr[6:0], 1'b0};
        end else begin
          rx_sr <= {rx_sr[6:0], miso};
        end
      end
      if (edge_n == 4'd15) busy <= 1'b0;
    end else begin
      cnt <= cnt + CW'(1);
    end
  end
endmodule

// File: rtl/spim_core.sv
module spim_core
  import spim_pkg::*;
#(
  parameter int unsigned NSS   = 8,
  parameter int unsigned QUEUE = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           reg_sel,
  input  logic           reg_wr,
  input  logic [2:0]     reg_addr,
  input  logic [7:0]     reg_wdata,
  output logic [7:0]     reg_rdata,
  output logic           irq,
  output logic           sck,
  output logic           mosi,
  input  logic           miso,
  output logic [NSS-1:0] ss_n
);
  logic [7:0]     ctl, ext;
  logic [NSS-1:0] sel_reg;
  logic           spif, wcol;
  logic [1:0]     xfer_cnt;

  logic we, re, data_we, ss_we, en, cpol, cpha;
  logic tx_push, tx_full, tx_empty, rx_pop, rx_full, rx_empty;
  logic [7:0] tx_dout, rx_dout, eng_rx;
  logic eng_pop, eng_done, eng_busy, cnt_hit;
  logic [3:0] hlog;

  assign we      = reg_sel && reg_wr;
  assign re      = reg_sel && !reg_wr;
  assign data_we = we && (reg_addr == OFS_DATA);
  assign ss_we   = we && (reg_addr == OFS_SEL);
  assign en      = ctl[6];
  assign cpol    = ctl[3];
  assign cpha    = ctl[2];
  assign hlog    = half_log({ext[1:0], ctl[1:0]});
  assign tx_push = data_we && en && !tx_full;
  assign rx_pop  = re && (reg_addr == OFS_DATA) && !rx_empty;
  assign cnt_hit = eng_done && (xfer_cnt == ext[7:6]);

  spim_fifo #(.W(8), .DEPTH(QUEUE)) tx_q (
    .clk(clk), .rst_n(rst_n), .flush(!en), .push(tx_push), .din(reg_wdata),
    .pop(eng_pop), .dout(tx_dout), .full(tx_full), .empty(tx_empty));

  spim_fifo #(.W(8), .DEPTH(QUEUE)) rx_q (
    .clk(clk), .rst_n(rst_n), .flush(!en), .push(eng_done), .din(eng_rx),
    .pop(rx_pop), .dout(rx_dout), .full(rx_full), .empty(rx_empty));

  spim_shift eng (
    .clk(clk), .rst_n(rst_n), .en(en), .cpol(cpol), .cpha(cpha), .hlog(hlog),
    .tx_avail(!tx_empty), .tx_byte(tx_dout), .miso(miso), .pop(eng_pop),
    .done(eng_done), .rx_byte(eng_rx), .busy(eng_busy), .sck(sck), .mosi(mosi));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl      <= '0;
      ext      <= '0;
      sel_reg  <= '0;
      spif     <= 1'b0;
      wcol     <= 1'b0;
      xfer_cnt <= '0;
    end else begin
      if (we && reg_addr == OFS_CTL) ctl <= reg_wdata & 8'hDF;
      if (we && reg_addr == OFS_EXT) ext <= reg_wdata & 8'hC3;
      if (ss_we) sel_reg <= reg_wdata[NSS-1:0];

      if (!en)           xfer_cnt <= '0;
      else if (cnt_hit)  xfer_cnt <= '0;
      else if (eng_done) xfer_cnt <= xfer_cnt + 2'd1;

      if (cnt_hit) spif <= 1'b1;
      else if (we && reg_addr == OFS_STAT && reg_wdata[7]) spif <= 1'b0;

      if (data_we && en && tx_full) wcol <= 1'b1;
      else if (we && reg_addr == OFS_STAT && reg_wdata[6]) wcol <= 1'b0;
    end
  end

  always_comb begin
    case (reg_addr)
      OFS_CTL:  reg_rdata = ctl;
      OFS_STAT: reg_rdata = {spif, wcol, 2'b00, tx_full, tx_empty, rx_full, rx_empty};
      OFS_DATA: reg_rdata = rx_empty ? 8'h00 : rx_dout;
      OFS_EXT:  reg_rdata = ext;
      OFS_SEL:  reg_rdata = 8'(sel_reg);
      default:  reg_rdata = 8'h00;
    endcase
  end

  assign irq  = spif && ctl[7];
  assign ss_n = ~sel_reg;
endmodule

// File: rtl/spim_chk.sv
module spim_chk #(
  parameter int unsigned NSS = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic           en,
  input logic           cpol,
  input logic           eng_busy,
  input logic           eng_done,
  input logic           sck,
  input logic           tx_empty,
  input logic           rx_empty,
  input logic           tx_full,
  input logic           data_we,
  input logic           wcol,
  input logic           spif,
  input logic           ss_we,
  input logic [NSS-1:0] ss_n
);
  assert_sck_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !eng_busy) |=> (sck == $past(cpol)));

  assert_flush_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (tx_empty && rx_empty));

  assert_collision_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (data_we && en && tx_full) |=> wcol);

  assert_flag_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spif) |-> $past(eng_done));

  assert_select_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !ss_we |=> $stable(ss_n));
endmodule

bind spim_core spim_chk #(.NSS(NSS)) chk_i (
  .clk(clk), .rst_n(rst_n), .en(en), .cpol(cpol), .eng_busy(eng_busy),
  .eng_done(eng_done), .sck(sck), .tx_empty(tx_empty), .rx_empty(rx_empty),
  .tx_full(tx_full), .data_we(data_we), .wcol(wcol), .spif(spif),
  .ss_we(ss_we), .ss_n(ss_n));

// File: tb/spim_core_tb_top.sv
module spim_core_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_sel = 1'b0, reg_wr = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic irq, sck, mosi;
  logic miso = 1'b0;
  logic [7:0] ss_n;

  int n_chk = 0, n_bad = 0;
  logic m_cpol = 0, m_cpha = 0;

  always #4 clk = ~clk;

  spim_core dut_i (.*);

  // SPI slave model
  logic [7:0] sl_tx [4];
  logic [7:0] sl_got [4];
  logic [7:0] sl_sr, sl_rx;
  int sl_idx = 0, sl_edge = 0;
  logic sl_on = 0;

  always @(sck) begin
    if (sl_on && !ss_n[0]) begin
      if (!m_cpha) begin
        if (sck != m_cpol) sl_rx = {sl_rx[6:0], mosi};
        else if (sl_edge != 15) sl_sr = {sl_sr[6:0], 1'b0};
      end else begin
        if (sck != m_cpol) begin
          if (sl_edge != 0) sl_sr = {sl_sr[6:0], 1'b0};
        end else sl_rx = {sl_rx[6:0], mosi};
      end
      sl_edge++;
      if (sl_edge == 16) begin
        sl_edge = 0;
        if (sl_idx < 4) sl_got[sl_idx] = sl_rx;
        sl_idx++;
        sl_sr = sl_tx[sl_idx < 4 ? sl_idx : 0];
      end
      miso = sl_sr[7];
    end
  end

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_sel = 1; reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_sel = 0; reg_wr = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_sel = 1; reg_wr = 0; reg_addr = a;
    #1 d = reg_rdata;
    @(posedge clk); #1;
    reg_sel = 0;
  endtask

  function automatic int exp_hlog(input int c);
    case (c)
      0: return 0; 1: return 1; 4: return 2; 2: return 3; 3: return 4;
      default: return (c > 11) ? 11 : c;
    endcase
  endfunction

  task automatic slave_arm(input int b);
    for (int i = 0; i < 4; i++) begin
      sl_tx[i] = 8'($urandom);
      sl_got[i] = 8'h00;
    end
    sl_idx = 0; sl_edge = 0; sl_rx = 0;
    sl_sr = sl_tx[0]; miso = sl_sr[7];
    sl_on = (b > 0);
  endtask

  // quiesce, then configure a mode; select stays released
  task automatic setup(input logic ie, input int code, input int icnt);
    wr(3'd4, 8'h00);
    wr(3'd0, 8'h00);
    wr(3'd1, 8'hC0);
    wr(3'd3, {2'(icnt), 4'b0, 2'(code >> 2)});
    wr(3'd0, {ie, 1'b1, 1'b0, 1'b1, m_cpol, m_cpha, 2'(code)});
    repeat (2) @(posedge clk);
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    logic [7:0] d;
    logic [7:0] txb [4];
    realtime t0, t1;
    void'($urandom(32'h5A17C0DE));
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    repeat (2) @(posedge clk);

    // R1: reset state
    rd(3'd0, d); chk(d == 8'h00, "R1 ctl", d, 0);
    rd(3'd1, d); chk(d == 8'h05, "R1 status", d, 5);
    rd(3'd2, d); chk(d == 8'h00, "R1 data", d, 0);
    rd(3'd3, d); chk(d == 8'h00, "R1 ext", d, 0);
    rd(3'd4, d); chk(d == 8'h00, "R1 sel", d, 0);
    #1 chk(ss_n == 8'hFF && irq == 0 && sck == 0, "R1 pins", {ss_n, irq, sck}, 32'h3FC);

    // R10: select lines
    wr(3'd4, 8'h08); #1 chk(ss_n == 8'hF7, "R10 select", ss_n, 8'hF7);
    repeat (3) @(posedge clk); #1 chk(ss_n == 8'hF7, "R10 hold", ss_n, 8'hF7);
    wr(3'd4, 8'h00); #1 chk(ss_n == 8'hFF, "R10 release", ss_n, 8'hFF);

    // R2: prescaler period for non-monotonic codes
    foreach (txb[i]) txb[i] = 0;
    for (int j = 0; j < 6; j++) begin
      int codes [6] = '{0, 1, 4, 2, 3, 11};
      int c = codes[j];
      m_cpol = 0; m_cpha = 0;
      setup(1'b0, c, 0);
      wr(3'd2, 8'hA5);
      @(posedge sck); t0 = $realtime;
      @(posedge sck); t1 = $realtime;
      chk(int'((t1 - t0) / 8.0) == (2 << exp_hlog(c)), "R2 period",
          int'((t1 - t0) / 8.0), 2 << exp_hlog(c));
    end
    wr(3'd0, 8'h00);

    // R6/R7: collision with full queue, then flush
    m_cpol = 0; m_cpha = 0;
    setup(1'b0, 3, 0);
    for (int i = 0; i < 6; i++) wr(3'd2, 8'(i));
    rd(3'd1, d); chk(d == 8'h49, "R6 collision status", d, 8'h49);
    wr(3'd1, 8'h40);
    rd(3'd1, d); chk(d[6] == 0, "R6 clear", d, 8'h09);
    wr(3'd0, 8'h00);
    repeat (2) @(posedge clk);
    rd(3'd1, d); chk(d == 8'h05, "R7 flush status", d, 5);
    rd(3'd2, d); chk(d == 8'h00, "R7 no data after flush", d, 0);
    #1 chk(sck == 0, "R7 sck", sck, 0);

    // R3/R4/R5/R8/R9: random bursts in all modes
    for (int it = 0; it < 40; it++) begin
      int codes [4] = '{0, 1, 4, 2};
      int c = codes[$urandom_range(0, 3)];
      int b = $urandom_range(1, 4);
      int icnt = $urandom_range(0, 3);
      logic ie = 1'($urandom);
      logic exp_f;
      m_cpol = 1'($urandom); m_cpha = 1'($urandom);
      setup(ie, c, icnt);
      #1 chk(sck == m_cpol, "R4 idle level", sck, m_cpol);
      slave_arm(b);
      wr(3'd4, 8'h01);
      for (int i = 0; i < b; i++) begin
        txb[i] = 8'($urandom);
        wr(3'd2, txb[i]);
      end
      repeat (b * ((16 << exp_hlog(c)) + 2) + 10) @(posedge clk);
      #1 chk(sck == m_cpol, "R4 idle after burst", sck, m_cpol);
      exp_f = (b >= icnt + 1);
      rd(3'd1, d);
      chk(d == {exp_f, 1'b0, 2'b00, 1'b0, 1'b1, 1'(b == 4), 1'b0}, "R5/R8 status", d,
          {exp_f, 1'b0, 2'b00, 1'b0, 1'b1, 1'(b == 4), 1'b0});
      #1 chk(irq == (ie & exp_f), "R9 irq", irq, ie & exp_f);
      for (int i = 0; i < b; i++) begin
        rd(3'd2, d);
        chk(d == sl_tx[i], "R3 master rx", d, sl_tx[i]);
        chk(sl_got[i] == txb[i], "R3 slave rx", sl_got[i], txb[i]);
      end
      rd(3'd2, d); chk(d == 8'h00, "R5 empty read", d, 0);
      rd(3'd1, d); chk(d[0] == 1, "R5 rx empty", d[0], 1);
      wr(3'd1, 8'h80);
      rd(3'd1, d); chk(d[7] == 0, "R8 clear", d[7], 0);
      #1 chk(irq == 0, "R9 irq clear", irq, 0);
      sl_on = 0;
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule